// File: doc/BRIEF.md
# Write-Through Store Queue with Way-Select Decoder

This block queues the stores that a write-through first-level cache sends toward the second-level cache. The processor does not wait for the L2 write to finish. Each queued store carries two sideband fields besides its address and data. The first is the L2 way that holds the line, taken from the way-tag lookup done alongside the L1 access. The second is a flag that marks the store as an L1 write miss. Both fields sit in storage that has the same depth as the address and data queue. They are written by the same push and freed by the same pop.

The oldest entry is presented to the L2 port. In the same cycle, a decoder turns its sideband into per-way enables. A store that hit in L1 enables only the tagged way, so the L2 behaves like a direct-mapped array for that store. A store that missed in L1 has no known way and enables all ways. Whenever the L2 port carries a read, all ways are enabled and no store is issued in that cycle.

Top module: `wtag_wbuf`

## Requirements
- R1: Stores leave on the L2 write port in exactly the order in which they were accepted, with their address and data unchanged.
- R2: When a store whose miss flag is 0 is presented and no read is active, `l2_way_en` has exactly one bit set. The set bit is bit k, where k is the stored way tag; for example, tag 2 gives 4'b0100.
- R3: When the presented store has its miss flag set to 1, every bit of `l2_way_en` is 1.
- R4: While `l2_rd` is 1, every bit of `l2_way_en` is 1, `l2_wr_valid` is 0, and no entry is removed.
- R5: After DEPTH stores are accepted with no removals, `full` is 1 and `push_ready` is 0. A push offered while full is dropped and never appears at the L2 port.
- R6: A push and a pop in the same cycle leave the occupancy unchanged: `empty` and `full` keep their values. The new entry queues behind the older ones.
- R7: After reset the queue is empty, `push_ready` is 1, `l2_wr_valid` is 0, and `l2_way_en` is all zero while no read is active.
- R8: The way enables are combinational. They change in the same cycle as the address and data presented at the L2 port.
- R9: The way tag and miss flag issued with a store are the values sampled on its push cycle.
- R10: While a store is presented and `l2_wr_ready` is 0, its address and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Store offered by the L1 side |
| push_ready | output | 1 | Queue can accept a store |
| push_addr | input | ADDR_W | Store address |
| push_data | input | DATA_W | Store data |
| push_way | input | TAG_W | L2 way tag read with the L1 access |
| push_miss | input | 1 | 1 when the store missed in L1 |
| l2_rd | input | 1 | A read access is using the L2 port this cycle |
| l2_wr_valid | output | 1 | A queued store is presented to L2 |
| l2_wr_ready | input | 1 | L2 takes the presented store |
| l2_wr_addr | output | ADDR_W | Address of the oldest store |
| l2_wr_data | output | DATA_W | Data of the oldest store |
| l2_way_en | output | WAYS | Per-way activation for the L2 arrays |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |

## Verification
The bench fills the queue to capacity and offers one more store. A design that let that store overwrite the oldest entry, or that slipped it in later, would show a wrong address during the drain or a non-empty queue afterward. The drain covers all four tag values with mixed miss flags. This catches a decoder that uses the wrong bit order, and one that ignores the miss flag and enables a single way. A read is raised while a store is waiting, so a design that popped during the read would lose that store. Push and pop are held together across several cycles, which shows up a counter that drifts or an order that breaks when both pointers move in the same cycle.

// File: rtl/wtb_pkg.sv
package wtb_pkg;
  // Advance a circular index, wrapping at depth.
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  // True when the store may use only its tagged way.
  function automatic logic single_way(logic rd, logic valid, logic miss);
    return valid && !rd && !miss;
  endfunction
endpackage

// File: rtl/wtb_fifo_ctrl.sv
module wtb_fifo_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_fire,
  input  logic             pop_fire,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             empty
);
  logic [CNT_W-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push_fire) wr_ptr <= PTR_W'(wtb_pkg::wrap_inc(32'(wr_ptr), DEPTH));
      if (pop_fire)  rd_ptr <= PTR_W'(wtb_pkg::wrap_inc(32'(rd_ptr), DEPTH));
      case ({push_fire, pop_fire})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign full  = (occ == CNT_W'(DEPTH));
  assign empty = (occ == '0);
endmodule

// File: rtl/wtb_store.sv
module wtb_store #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              in_miss,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_miss
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic              miss_q [DEPTH];

  // Payload and sideband share one write strobe per slot.
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && wr_ptr == PTR_W'(e)) begin
        addr_q[e] <= in_addr;
        data_q[e] <= in_data;
        tag_q[e]  <= in_tag;
        miss_q[e] <= in_miss;
      end
    end
  end

  assign out_addr = addr_q[rd_ptr];
  assign out_data = data_q[rd_ptr];
  assign out_tag  = tag_q[rd_ptr];
  assign out_miss = miss_q[rd_ptr];
endmodule

// File: rtl/wtb_way_dec.sv
module wtb_way_dec #(
  parameter int WAYS = 4,
  localparam int TAG_W = $clog2(WAYS)
) (
  input  logic             valid,
  input  logic             rd,
  input  logic             miss,
  input  logic [TAG_W-1:0] tag,
  output logic [WAYS-1:0]  way_en
);
  logic force_all;
  logic narrow;

  assign force_all = rd || (valid && miss);
  assign narrow    = wtb_pkg::single_way(rd, valid, miss);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_en[w] = force_all || (narrow && tag == TAG_W'(w));
  end
endmodule

// File: rtl/wtag_wbuf.sv
module wtag_wbuf #(
  parameter int DEPTH  = 8,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic [TAG_W-1:0]  push_way,
  input  logic              push_miss,
  input  logic              l2_rd,
  output logic              l2_wr_valid,
  input  logic              l2_wr_ready,
  output logic [ADDR_W-1:0] l2_wr_addr,
  output logic [DATA_W-1:0] l2_wr_data,
  output logic [WAYS-1:0]   l2_way_en,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = $clog2(DEPTH);

  logic             push_fire;
  logic             pop_fire;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [TAG_W-1:0] head_tag;
  logic             head_miss;

  assign push_ready  = !full;
  assign push_fire   = push_valid && push_ready;
  assign l2_wr_valid = !empty && !l2_rd;
  assign pop_fire    = l2_wr_valid && l2_wr_ready;

  wtb_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .full      (full),
    .empty     (empty)
  );

  wtb_store #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_store (
    .clk      (clk),
    .we       (push_fire),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .in_addr  (push_addr),
    .in_data  (push_data),
    .in_tag   (push_way),
    .in_miss  (push_miss),
    .out_addr (l2_wr_addr),
    .out_data (l2_wr_data),
    .out_tag  (head_tag),
    .out_miss (head_miss)
  );

  wtb_way_dec #(.WAYS(WAYS)) u_dec (
    .valid  (!empty),
    .rd     (l2_rd),
    .miss   (head_miss),
    .tag    (head_tag),
    .way_en (l2_way_en)
  );
endmodule

// File: rtl/wtag_wbuf_chk.sv
module wtag_wbuf_chk #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l2_rd,
  input logic              l2_wr_valid,
  input logic              l2_wr_ready,
  input logic [ADDR_W-1:0] l2_wr_addr,
  input logic [DATA_W-1:0] l2_wr_data,
  input logic [WAYS-1:0]   l2_way_en,
  input logic              head_miss,
  input logic              push_fire,
  input logic              pop_fire,
  input logic              full,
  input logic              empty
);
  a_r2_hit_single_way: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_wr_valid && !head_miss) |-> $countones(l2_way_en) == 1);

  a_r3_miss_all_ways: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_wr_valid && head_miss) |-> &l2_way_en);

  a_r4_read_all_ways: assert property (@(posedge clk) disable iff (!rst_n)
    l2_rd |-> (&l2_way_en && !pop_fire));

  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_fire) |=> full);

  a_r6_same_cycle_occ: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire) |=> (full == $past(full) && empty == $past(empty)));

  a_r7_idle_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !l2_rd) |-> l2_way_en == '0);

  a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_wr_valid && !l2_wr_ready) |=> ($stable(l2_wr_addr) && $stable(l2_wr_data)));

  always_comb begin
    a_r5_flags_exclusive: assert (!(full && empty) || !rst_n);
  end
endmodule

bind wtag_wbuf wtag_wbuf_chk #(.WAYS(WAYS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .l2_rd       (l2_rd),
  .l2_wr_valid (l2_wr_valid),
  .l2_wr_ready (l2_wr_ready),
  .l2_wr_addr  (l2_wr_addr),
  .l2_wr_data  (l2_wr_data),
  .l2_way_en   (l2_way_en),
  .head_miss   (head_miss),
  .push_fire   (push_fire),
  .pop_fire    (pop_fire),
  .full        (full),
  .empty       (empty)
);

// File: tb/wtag_wbuf_test.sv
`timescale 1ns/1ps
module wtag_wbuf_test;
  localparam int DEPTH = 8;
  localparam int WAYS  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic        push_ready;
  logic [15:0] push_addr = '0;
  logic [31:0] push_data = '0;
  logic [1:0]  push_way = '0;
  logic        push_miss = 1'b0;
  logic        l2_rd = 1'b0;
  logic        l2_wr_valid;
  logic        l2_wr_ready = 1'b0;
  logic [15:0] l2_wr_addr;
  logic [31:0] l2_wr_data;
  logic [3:0]  l2_way_en;
  logic        full;
  logic        empty;

  int checks = 0;
  int fails  = 0;

  // Vector: {addr[50:35], data[34:3], tag[2:1], miss[0]}
  localparam logic [50:0] VEC [8] = '{
    {16'h1000, 32'hA0A0_0001, 2'd0, 1'b0},
    {16'h1004, 32'hB1B1_0002, 2'd1, 1'b0},
    {16'h2008, 32'hC2C2_0003, 2'd2, 1'b1},
    {16'h200C, 32'hD3D3_0004, 2'd3, 1'b0},
    {16'h3010, 32'hE4E4_0005, 2'd2, 1'b0},
    {16'h3014, 32'hF5F5_0006, 2'd1, 1'b1},
    {16'h4018, 32'h0606_0007, 2'd3, 1'b1},
    {16'h401C, 32'h1717_0008, 2'd0, 1'b0}
  };

  wtag_wbuf uut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_addr(push_addr), .push_data(push_data),
    .push_way(push_way), .push_miss(push_miss),
    .l2_rd(l2_rd), .l2_wr_valid(l2_wr_valid), .l2_wr_ready(l2_wr_ready),
    .l2_wr_addr(l2_wr_addr), .l2_wr_data(l2_wr_data),
    .l2_way_en(l2_way_en), .full(full), .empty(empty)
  );

  always #2.5 clk = ~clk;

  function automatic logic [3:0] exp_en(logic [1:0] tag, logic miss);
    return miss ? 4'b1111 : (4'b0001 << tag);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #0.5;
  endtask

  task automatic drive_push(logic [50:0] v);
    push_valid = 1'b1;
    push_addr  = v[50:35];
    push_data  = v[34:3];
    push_way   = v[2:1];
    push_miss  = v[0];
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired (all R) actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    // R7: reset state
    check(empty == 1'b1, "R7 empty after reset", empty, 1);
    check(full == 1'b0 && push_ready == 1'b1, "R7 ready after reset", {full, push_ready}, 2'b01);
    check(l2_wr_valid == 1'b0, "R7 no issue after reset", l2_wr_valid, 0);
    check(l2_way_en == 4'b0000, "R7 enables idle", l2_way_en, 0);
    rst_n = 1'b1;
    tick();

    // R5/R9: fill with stall on the L2 side
    for (int i = 0; i < DEPTH; i++) begin
      drive_push(VEC[i]);
      tick();
    end
    push_valid = 1'b0;
    check(full == 1'b1 && push_ready == 1'b0, "R5 full after DEPTH pushes", {full, push_ready}, 2'b10);
    // R10: oldest entry held while ready low
    check(l2_wr_addr == VEC[0][50:35] && l2_wr_data == VEC[0][34:3],
          "R10 head stable under stall", {l2_wr_addr, l2_wr_data}, {VEC[0][50:35], VEC[0][34:3]});
    // R5: extra push must be dropped
    drive_push({16'hDEAD, 32'hDEAD_BEEF, 2'd3, 1'b0});
    tick();
    push_valid = 1'b0;
    check(full == 1'b1, "R5 still full after refused push", full, 1);

    // R1/R2/R3/R8/R9: drain in order, checking enables in the same cycle
    l2_wr_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      check(l2_wr_valid == 1'b1, "R1 entry presented", l2_wr_valid, 1);
      check(l2_wr_addr == VEC[i][50:35] && l2_wr_data == VEC[i][34:3], "R1 order and payload",
            {l2_wr_addr, l2_wr_data}, {VEC[i][50:35], VEC[i][34:3]});
      check(l2_way_en == exp_en(VEC[i][2:1], VEC[i][0]),
            VEC[i][0] ? "R3 miss enables all (R8 R9)" : "R2 hit one-hot (R8 R9)",
            l2_way_en, exp_en(VEC[i][2:1], VEC[i][0]));
      tick();
    end
    l2_wr_ready = 1'b0;
    check(empty == 1'b1, "R5 refused push never queued", empty, 1);

    // R4: a read blocks the pop and opens all ways
    drive_push({16'h5550, 32'h5555_AAAA, 2'd2, 1'b0});
    tick();
    push_valid = 1'b0;
    l2_rd = 1'b1;
    l2_wr_ready = 1'b1;
    #0.5;
    check(l2_way_en == 4'b1111, "R4 read enables all", l2_way_en, 4'hF);
    check(l2_wr_valid == 1'b0, "R4 no store during read", l2_wr_valid, 0);
    tick();
    l2_rd = 1'b0;
    #0.5;
    check(empty == 1'b0 && l2_wr_addr == 16'h5550, "R4 store kept across read",
          {empty, l2_wr_addr}, {1'b0, 16'h5550});
    check(l2_way_en == 4'b0100, "R2 tag 2 after read", l2_way_en, 4'b0100);
    tick();
    l2_wr_ready = 1'b0;
    check(empty == 1'b1, "R4 store issued after read", empty, 1);

    // R6: simultaneous push and pop
    drive_push(VEC[1]);
    tick();
    l2_wr_ready = 1'b1;
    for (int j = 2; j < 6; j++) begin
      drive_push(VEC[j]);
      #0.5;
      check(l2_wr_addr == VEC[j-1][50:35], "R6 order under push+pop", l2_wr_addr, VEC[j-1][50:35]);
      tick();
      check(empty == 1'b0 && full == 1'b0, "R6 occupancy unchanged", {empty, full}, 2'b00);
    end
    push_valid = 1'b0;
    #0.5;
    check(l2_wr_addr == VEC[5][50:35] && l2_way_en == 4'b1111, "R6 last entry with miss (R3)",
          {l2_wr_addr, l2_way_en}, {VEC[5][50:35], 4'hF});
    tick();
    l2_wr_ready = 1'b0;
    check(empty == 1'b1 && l2_way_en == 4'b0000, "R7 idle after drain", {empty, l2_way_en}, 5'b10000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule